// File: doc/BRIEF.md
# Chained DMA Tag Sequencer

This block is the step of a source-chain DMA channel that interprets one tag. Another block fetches a tag from memory at the current tag pointer, splits it into a 3-bit kind, a quadword count and an embedded address, and presents it with a one-cycle strobe. The sequencer then updates two address registers:
- the data pointer, which says where the payload is read from;
- the tag pointer, which says where the next tag is fetched from.

It reports whether the chain stops at this tag.

A two-slot return stack supports subroutine-style chains. A call tag saves the address that follows its payload, and a return tag resumes there. A mode input disables the stack, and the call and return kinds then do nothing. A start strobe loads the tag pointer and empties the stack before a new chain. The embedded address of every tag is treated as the preloaded value of the data pointer. Tags that leave the data pointer alone therefore leave it equal to that address.

Top module: `chain_tag_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it, `madr`, `tadr`, `asr0`, `asr1` and `stack_ptr` read 0, and `result_valid`, `chain_end` and `stack_ovf` are low.
- R2: A `start_valid` pulse loads `tadr` with `start_tadr`, clears `asr0`, `asr1` and `stack_ptr`, and produces no result. It takes priority over a tag in the same cycle.
- R3: Each accepted `tag_valid` pulse gives exactly one `result_valid` pulse in the next cycle. All register updates and both flags appear in that cycle.
- R4: Kind 0 (terminal reference) sets `madr` to `tag_addr`, leaves `tadr` unchanged and raises `chain_end`.
- R5: Kind 1 (count) sets `madr` to `tadr`+16 and then sets `tadr` to the new `madr` plus `tag_qwc`×16.
- R6: Kind 2 (jump) sets `madr` to `tadr`+16 and `tadr` to `tag_addr`.
- R7: Kinds 3 and 4 (reference, and reference with stall) set `madr` to `tag_addr` and advance `tadr` by 16.
- R8: Kind 5 (call), with the stack enabled and `stack_ptr` below 2, sets `madr` to `tadr`+16. It writes `madr`+`tag_qwc`×16 into `asr0` when `stack_ptr` is 0, or into `asr1` when it is 1, then increments `stack_ptr` and sets `tadr` to `tag_addr`.
- R9: Kind 5 with `stack_ptr` at 2 sets `madr` to `tadr`+16. It leaves `tadr`, `asr0`, `asr1` and `stack_ptr` unchanged and raises both `chain_end` and `stack_ovf`.
- R10: Kind 6 (return), with the stack enabled and `stack_ptr` nonzero, sets `madr` to `tadr`+16. It loads `tadr` from `asr1` when `stack_ptr` is 2, or from `asr0` when it is 1, clears that slot and decrements `stack_ptr`.
- R11: Kind 6 with `stack_ptr` at 0 sets `madr` to `tadr`+16, leaves `tadr` unchanged and raises `chain_end`.
- R12: Kind 7 (end) sets `madr` to `tadr`+16, leaves `tadr` unchanged and raises `chain_end`.
- R13: With `stack_en` low, kinds 5 and 6 set `madr` to `tag_addr`. They leave `tadr` and the stack unchanged and do not raise `chain_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stack_en | input | 1 | Enables call/return stack handling |
| start_valid | input | 1 | Starts a chain: loads tag pointer, empties stack |
| start_tadr | input | AW | Initial tag pointer |
| tag_valid | input | 1 | Decoded tag present this cycle |
| tag_id | input | 3 | Tag kind |
| tag_qwc | input | QW | Payload length in quadwords |
| tag_addr | input | AW | Embedded address (preloaded data pointer) |
| madr | output | AW | Data pointer |
| tadr | output | AW | Tag pointer |
| asr0 | output | AW | Return stack slot 0 |
| asr1 | output | AW | Return stack slot 1 |
| stack_ptr | output | 2 | Number of occupied stack slots |
| result_valid | output | 1 | Pulse: a tag's result is visible |
| chain_end | output | 1 | With result_valid: the chain stops here |
| stack_ovf | output | 1 | With result_valid: call found the stack full |

## Verification
Linear chains of count, jump and reference tags with different quadword counts show whether the data pointer and tag pointer are each derived from the right source: the embedded address, the old tag pointer, or the new data pointer. A nested pair of calls followed by three returns fills the stack and then drains it. This shows which slot each push and pop uses and whether a popped slot is cleared. A third call on a full stack and a return on an empty stack exercise both stopping paths. Call and return tags sent with the stack disabled and a slot occupied show that the mode leaves the stack untouched. A start strobe after a partly used stack shows the stack is emptied.

// File: rtl/chain_tag_seq_pkg.sv
package chain_tag_seq_pkg;
  typedef enum logic [2:0] {
    TK_TERMREF = 3'd0,
    TK_COUNT   = 3'd1,
    TK_JUMP    = 3'd2,
    TK_REF     = 3'd3,
    TK_REFSTL  = 3'd4,
    TK_CALL    = 3'd5,
    TK_RETURN  = 3'd6,
    TK_FINISH  = 3'd7
  } tag_kind_e;

  localparam int STACK_DEPTH = 2;
  localparam int SP_W        = $clog2(STACK_DEPTH + 1);
  localparam int QW_BYTES    = 16;
  localparam int QW_SHIFT    = $clog2(QW_BYTES);
endpackage

// File: rtl/cts_rule.sv
module cts_rule
  import chain_tag_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int QW = 16
) (
  input  logic [2:0]    tag_id,
  input  logic [QW-1:0] tag_qwc,
  input  logic [AW-1:0] tag_addr,
  input  logic [AW-1:0] tadr_q,
  input  logic          stack_en,
  input  logic          stk_full,
  input  logic          stk_empty,
  input  logic [AW-1:0] stk_top,
  output logic [AW-1:0] madr_n,
  output logic [AW-1:0] tadr_n,
  output logic          push,
  output logic          pop,
  output logic [AW-1:0] push_data,
  output logic          end_n,
  output logic          ovf_n
);
  localparam logic [AW-1:0] STEP = AW'(QW_BYTES);

  logic [AW-1:0] after_tag;
  logic [AW-1:0] span;
  tag_kind_e     kind;

  assign after_tag = tadr_q + STEP;
  assign span      = AW'(tag_qwc) << QW_SHIFT;
  assign kind      = tag_kind_e'(tag_id);

  always_comb begin
    madr_n    = tag_addr;
    tadr_n    = tadr_q;
    push      = 1'b0;
    pop       = 1'b0;
    push_data = after_tag + span;
    end_n     = 1'b0;
    ovf_n     = 1'b0;
    unique case (kind)
      TK_TERMREF: end_n = 1'b1;
      TK_COUNT: begin
        madr_n = after_tag;
        tadr_n = after_tag + span;
      end
      TK_JUMP: begin
        madr_n = after_tag;
        tadr_n = tag_addr;
      end
      TK_REF, TK_REFSTL: tadr_n = after_tag;
      TK_CALL: begin
        if (stack_en) begin
          madr_n = after_tag;
          if (stk_full) begin
            end_n = 1'b1;
            ovf_n = 1'b1;
          end else begin
            push   = 1'b1;
            tadr_n = tag_addr;
          end
        end
      end
      TK_RETURN: begin
        if (stack_en) begin
          madr_n = after_tag;
          if (stk_empty) begin
            end_n = 1'b1;
          end else begin
            pop    = 1'b1;
            tadr_n = stk_top;
          end
        end
      end
      TK_FINISH: begin
        madr_n = after_tag;
        end_n  = 1'b1;
      end
      default: end_n = 1'b1;
    endcase
  end
endmodule

// File: rtl/cts_stack.sv
module cts_stack
  import chain_tag_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            push,
  input  logic            pop,
  input  logic [AW-1:0]   push_data,
  output logic [AW-1:0]   slot [STACK_DEPTH],
  output logic [SP_W-1:0] sp,
  output logic [AW-1:0]   top,
  output logic            full,
  output logic            empty
);
  logic [SP_W-1:0] sp_q;

  for (genvar i = 0; i < STACK_DEPTH; i++) begin : g_slot
    logic [AW-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst || clear)
        slot_q <= '0;
      else if (push && sp_q == SP_W'(i))
        slot_q <= push_data;
      else if (pop && sp_q == SP_W'(i + 1))
        slot_q <= '0;
    end
    assign slot[i] = slot_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clear)
      sp_q <= '0;
    else if (push && !full)
      sp_q <= sp_q + SP_W'(1);
    else if (pop && !empty)
      sp_q <= sp_q - SP_W'(1);
  end

  always_comb begin
    top = '0;
    for (int i = 0; i < STACK_DEPTH; i++)
      if (sp_q == SP_W'(i + 1)) top = slot[i];
  end

  assign sp    = sp_q;
  assign full  = (sp_q == SP_W'(STACK_DEPTH));
  assign empty = (sp_q == '0);
endmodule

// File: rtl/cts_addr_regs.sv
module cts_addr_regs #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_start,
  input  logic [AW-1:0] start_tadr,
  input  logic          fire,
  input  logic [AW-1:0] madr_n,
  input  logic [AW-1:0] tadr_n,
  input  logic          end_n,
  input  logic          ovf_n,
  output logic [AW-1:0] madr_q,
  output logic [AW-1:0] tadr_q,
  output logic          valid_q,
  output logic          end_q,
  output logic          ovf_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      madr_q  <= '0;
      tadr_q  <= '0;
      valid_q <= 1'b0;
      end_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      valid_q <= fire;
      end_q   <= fire && end_n;
      ovf_q   <= fire && ovf_n;
      if (load_start) begin
        tadr_q <= start_tadr;
      end else if (fire) begin
        madr_q <= madr_n;
        tadr_q <= tadr_n;
      end
    end
  end
endmodule

// File: rtl/chain_tag_seq.sv
module chain_tag_seq
  import chain_tag_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stack_en,
  input  logic          start_valid,
  input  logic [AW-1:0] start_tadr,
  input  logic          tag_valid,
  input  logic [2:0]    tag_id,
  input  logic [QW-1:0] tag_qwc,
  input  logic [AW-1:0] tag_addr,
  output logic [AW-1:0] madr,
  output logic [AW-1:0] tadr,
  output logic [AW-1:0] asr0,
  output logic [AW-1:0] asr1,
  output logic [1:0]    stack_ptr,
  output logic          result_valid,
  output logic          chain_end,
  output logic          stack_ovf
);
  logic            fire;
  logic [AW-1:0]   madr_n, tadr_n, push_data, stk_top;
  logic            push_raw, pop_raw, end_n, ovf_n, stk_full, stk_empty;
  logic [AW-1:0]   slots [STACK_DEPTH];
  logic [SP_W-1:0] sp;

  assign fire = tag_valid && !start_valid;

  cts_rule #(.AW(AW), .QW(QW)) u_rule (
    .tag_id    (tag_id),
    .tag_qwc   (tag_qwc),
    .tag_addr  (tag_addr),
    .tadr_q    (tadr),
    .stack_en  (stack_en),
    .stk_full  (stk_full),
    .stk_empty (stk_empty),
    .stk_top   (stk_top),
    .madr_n    (madr_n),
    .tadr_n    (tadr_n),
    .push      (push_raw),
    .pop       (pop_raw),
    .push_data (push_data),
    .end_n     (end_n),
    .ovf_n     (ovf_n)
  );

  cts_stack #(.AW(AW)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .clear     (start_valid),
    .push      (fire && push_raw),
    .pop       (fire && pop_raw),
    .push_data (push_data),
    .slot      (slots),
    .sp        (sp),
    .top       (stk_top),
    .full      (stk_full),
    .empty     (stk_empty)
  );

  cts_addr_regs #(.AW(AW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .load_start (start_valid),
    .start_tadr (start_tadr),
    .fire       (fire),
    .madr_n     (madr_n),
    .tadr_n     (tadr_n),
    .end_n      (end_n),
    .ovf_n      (ovf_n),
    .madr_q     (madr),
    .tadr_q     (tadr),
    .valid_q    (result_valid),
    .end_q      (chain_end),
    .ovf_q      (stack_ovf)
  );

  assign asr0      = slots[0];
  assign asr1      = slots[1];
  assign stack_ptr = 2'(sp);
endmodule

// File: rtl/chain_tag_seq_chk.sv
module chain_tag_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          stack_en,
  input logic          start_valid,
  input logic          tag_valid,
  input logic [2:0]    tag_id,
  input logic [AW-1:0] tadr,
  input logic [AW-1:0] asr0,
  input logic [AW-1:0] asr1,
  input logic [1:0]    stack_ptr,
  input logic          result_valid,
  input logic          chain_end,
  input logic          stack_ovf
);
  AST_SP_RANGE: assert property (@(posedge clk) disable iff (rst)
    stack_ptr != 2'd3); // R8
  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (rst)
    tag_valid && !start_valid |=> result_valid); // R3
  AST_SP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !result_valid && !$past(start_valid) |-> $stable(stack_ptr)); // R3
  AST_END_HOLDS_TADR: assert property (@(posedge clk) disable iff (rst)
    result_valid && chain_end |-> tadr == $past(tadr)); // R12
  AST_NO_OVERFLOW_PUSH: assert property (@(posedge clk) disable iff (rst)
    stack_ovf |-> chain_end && stack_ptr == 2'd2 && $stable(asr0) && $stable(asr1)); // R9
  AST_MODE_OFF_NOP: assert property (@(posedge clk) disable iff (rst)
    result_valid && !$past(stack_en) && ($past(tag_id) == 3'd5 || $past(tag_id) == 3'd6)
    |-> !chain_end && $stable(stack_ptr) && tadr == $past(tadr)); // R13
endmodule

bind chain_tag_seq chain_tag_seq_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .stack_en     (stack_en),
  .start_valid  (start_valid),
  .tag_valid    (tag_valid),
  .tag_id       (tag_id),
  .tadr         (tadr),
  .asr0         (asr0),
  .asr1         (asr1),
  .stack_ptr    (stack_ptr),
  .result_valid (result_valid),
  .chain_end    (chain_end),
  .stack_ovf    (stack_ovf)
);

// File: tb/sim_chain_tag_seq.sv
`timescale 1ns/1ps
module sim_chain_tag_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stack_en = 1'b1;
  logic        start_valid = 1'b0;
  logic [31:0] start_tadr = '0;
  logic        tag_valid = 1'b0;
  logic [2:0]  tag_id = '0;
  logic [15:0] tag_qwc = '0;
  logic [31:0] tag_addr = '0;
  logic [31:0] madr, tadr, asr0, asr1;
  logic [1:0]  stack_ptr;
  logic        result_valid, chain_end, stack_ovf;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  chain_tag_seq u0 (.*);

  typedef struct {
    logic [31:0] madr, tadr, asr0, asr1;
    logic [1:0]  sp;
    logic        fin, ovf;
  } exp_t;

  exp_t  expq[$];
  string reqq[$];

  logic [31:0] m_tadr = '0, m_asr0 = '0, m_asr1 = '0;
  int          m_sp = 0;

  task automatic cmp(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic start(input logic [31:0] a);
    @(negedge clk);
    start_valid = 1'b1; start_tadr = a;
    @(negedge clk);
    start_valid = 1'b0;
    m_tadr = a; m_asr0 = '0; m_asr1 = '0; m_sp = 0;
    cmp("R2", "tadr", tadr, a);
    cmp("R2", "stack", {asr0 | asr1, 30'd0, stack_ptr}, '0);
    cmp("R2", "result_valid", {31'd0, result_valid}, '0);
  endtask

  task automatic send(input logic [2:0] id, input logic [15:0] q, input logic [31:0] a, input string rq);
    exp_t e;
    logic [31:0] aft, spn;
    aft = m_tadr + 32'd16;
    spn = {12'd0, q, 4'd0};
    e.madr = a; e.fin = 1'b0; e.ovf = 1'b0;
    case (id)
      3'd0: e.fin = 1'b1;
      3'd1: begin e.madr = aft; m_tadr = aft + spn; end
      3'd2: begin e.madr = aft; m_tadr = a; end
      3'd3, 3'd4: m_tadr = aft;
      3'd5: if (stack_en) begin
        e.madr = aft;
        if (m_sp == 2) begin e.fin = 1'b1; e.ovf = 1'b1; end
        else begin
          if (m_sp == 0) m_asr0 = aft + spn; else m_asr1 = aft + spn;
          m_sp++; m_tadr = a;
        end
      end
      3'd6: if (stack_en) begin
        e.madr = aft;
        if (m_sp == 0) e.fin = 1'b1;
        else if (m_sp == 2) begin m_tadr = m_asr1; m_asr1 = '0; m_sp--; end
        else begin m_tadr = m_asr0; m_asr0 = '0; m_sp--; end
      end
      default: begin e.madr = aft; e.fin = 1'b1; end
    endcase
    e.tadr = m_tadr; e.asr0 = m_asr0; e.asr1 = m_asr1; e.sp = 2'(m_sp);
    expq.push_back(e); reqq.push_back(rq);
    @(negedge clk);
    tag_valid = 1'b1; tag_id = id; tag_qwc = q; tag_addr = a;
    @(negedge clk);
    tag_valid = 1'b0;
  endtask

  // Monitor: pops one expected item for every result pulse (R3)
  always @(negedge clk) begin
    if (!rst && result_valid) begin
      if (expq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3 result_valid: actual 1 expected 0 (no tag pending)");
      end else begin
        exp_t  e;
        string rq;
        e = expq.pop_front(); rq = reqq.pop_front();
        cmp(rq, "madr", madr, e.madr);
        cmp(rq, "tadr", tadr, e.tadr);
        cmp(rq, "asr0", asr0, e.asr0);
        cmp(rq, "asr1", asr1, e.asr1);
        cmp(rq, "stack_ptr", {30'd0, stack_ptr}, {30'd0, e.sp});
        cmp(rq, "chain_end", {31'd0, chain_end}, {31'd0, e.fin});
        cmp(rq, "stack_ovf", {31'd0, stack_ovf}, {31'd0, e.ovf});
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1", "madr", madr, '0);
    cmp("R1", "tadr|asr", tadr | asr0 | asr1, '0);
    cmp("R1", "flags", {27'd0, stack_ptr, result_valid, chain_end, stack_ovf}, '0);
    rst = 1'b0;
    @(negedge clk);
    cmp("R1", "after reset", {madr | tadr, 27'd0, stack_ptr, result_valid, chain_end, stack_ovf}, '0);

    start(32'h0000_1000);
    send(3'd1, 16'd3,  32'hDEAD_0000, "R5");
    send(3'd1, 16'd0,  32'h0,         "R5");
    send(3'd2, 16'd2,  32'h0000_2000, "R6");
    send(3'd3, 16'd5,  32'h0000_8000, "R7");
    send(3'd4, 16'd1,  32'h0000_9000, "R7");
    send(3'd5, 16'd2,  32'h0000_3000, "R8");
    send(3'd5, 16'd1,  32'h0000_4000, "R8");
    send(3'd5, 16'd4,  32'h0000_5000, "R9");
    send(3'd6, 16'd0,  32'h0,         "R10");
    send(3'd6, 16'd0,  32'h0,         "R10");
    send(3'd6, 16'd0,  32'h0,         "R11");
    send(3'd7, 16'd7,  32'h0000_7000, "R12");
    send(3'd0, 16'd2,  32'h0000_A000, "R4");

    start(32'h0001_0000);
    send(3'd5, 16'd1,  32'h0002_0000, "R8");
    stack_en = 1'b0;
    send(3'd5, 16'd3,  32'h0003_0000, "R13");
    send(3'd6, 16'd3,  32'h0004_0000, "R13");
    stack_en = 1'b1;
    send(3'd6, 16'd0,  32'h0,         "R10");
    send(3'd5, 16'd2,  32'h0005_0000, "R8");
    start(32'h0006_0000);
    send(3'd6, 16'd0,  32'h0,         "R11");

    repeat (4) @(negedge clk);
    cmp("R3", "pending results", 32'(expq.size()), '0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule